// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Masks

This block holds four BCD alarm registers: seconds, minutes, hours and day of month. On each one-second tick it compares them with the running calendar and raises a one-cycle interrupt pulse when the alarm condition is met. Bit 7 of each alarm register is a mask bit. The pattern formed by the four mask bits selects how often the alarm repeats: once a month, once a day, once an hour, once a minute or once a second. Masked fields take no part in the comparison.

Software writes the registers through a strobe, a field select and a data byte. A write whose decoded value is out of range is dropped, and the register keeps its previous contents. A combinational read port returns any register. The calendar counter lives outside this block and supplies BCD fields. Interrupt enable gating is also outside the block.

Field select encoding is 0 for seconds, 1 for minutes, 2 for hours and 3 for date.

Top module: `rtc_alarm`

## Requirements
- R1: After reset, all four alarm registers read 0x00 and irq_o is low.
- R2: An accepted write stores the whole byte, including bit 7 and any unused bits, and the register reads back unchanged until the next accepted write to it.
- R3: A write to seconds (select 0) or minutes (select 1) is accepted only when tens(bits 6:4)*10 + ones(bits 3:0) is at most 59. Otherwise the register is unchanged.
- R4: A write to hours (select 2) is accepted only when tens(bits 5:4)*10 + ones(bits 3:0) is at most 23. Otherwise the register is unchanged.
- R5: A write to date (select 3) is accepted only when tens(bit 4)*10 + ones(bits 3:0) is nonzero. Otherwise the register is unchanged.
- R6: With all four mask bits clear, the alarm fires only when date, hours, minutes and seconds all equal the calendar.
- R7: With only the date mask set, the alarm fires when hours, minutes and seconds match, regardless of the date.
- R8: With the date and hours masks set, and the minutes and seconds masks clear, the alarm fires when minutes and seconds match.
- R9: With the date, hours and minutes masks set, and the seconds mask clear, the alarm fires when seconds match.
- R10: Every other mask combination makes the alarm fire on every tick.
- R11: A comparison is evaluated only at a rising edge of tick_i. A hit drives irq_o high for exactly one cycle, in the cycle after that edge. Without a tick edge, irq_o stays low.
- R12: Holding tick_i high for several cycles produces at most one pulse.
- R13: A compared field uses bits 6:0 of the alarm register against the 7-bit calendar field. Bit 7 never enters the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick; its rising edge triggers a comparison |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write field select (0 sec, 1 min, 2 hour, 3 date) |
| wr_data_i | input | 8 | Write data: mask in bit 7, BCD value below it |
| rd_sel_i | input | 2 | Read field select |
| rd_data_o | output | 8 | Selected alarm register contents |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 7 | Calendar hours, BCD |
| cal_date_i | input | 7 | Calendar day of month, BCD |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
The bench writes every one of the 256 byte values to each of the four fields. A wrong limit, a wrong BCD weight or a wrong bit slice shows up as a byte stored when it should be dropped, or dropped when it should be stored. For each of the 16 mask patterns, the bench fires a tick with a full calendar match, and again with exactly one field disturbed. A wrong prefix decode would then fire in the wrong mode, or ignore a mismatch in a field it should compare. Two further tests cover tick handling. Ticks held high must not produce repeated pulses. Matches without a tick edge must produce no pulse at all.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int REG_W      = 8;
  localparam int VAL_W      = REG_W - 1;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  localparam logic [SEL_W-1:0] IDX_SEC  = 2'd0;
  localparam logic [SEL_W-1:0] IDX_MIN  = 2'd1;
  localparam logic [SEL_W-1:0] IDX_HOUR = 2'd2;
  localparam logic [SEL_W-1:0] IDX_DATE = 2'd3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } rpt_mode_e;

  typedef logic [NUM_FIELDS-1:0][REG_W-1:0] alarm_bank_t;
  typedef logic [NUM_FIELDS-1:0][VAL_W-1:0] cal_bank_t;

  function automatic logic [6:0] bcd_bin(input logic [2:0] tens, input logic [3:0] ones);
    return 7'(tens) * 7'd10 + 7'(ones);
  endfunction

  function automatic logic value_ok(input logic [SEL_W-1:0] idx, input logic [VAL_W-1:0] v);
    case (idx)
      IDX_SEC, IDX_MIN: return bcd_bin(v[6:4], v[3:0]) <= 7'd59;
      IDX_HOUR:         return bcd_bin({1'b0, v[5:4]}, v[3:0]) <= 7'd23;
      default:          return bcd_bin({2'b00, v[4]}, v[3:0]) != 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output alarm_bank_t      bank_o
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [REG_W-1:0] q;
    logic             accept;

    assign accept = wr_en_i && (wr_sel_i == SEL_W'(i))
                    && value_ok(SEL_W'(i), wr_data_i[VAL_W-1:0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (accept) q <= wr_data_i;
    end

    assign bank_o[i] = q;
  end
endmodule

// File: rtl/rtc_alarm_mode_dec.sv
module rtc_alarm_mode_dec
  import rtc_alarm_pkg::*;
(
  input  alarm_bank_t           bank_i,
  output logic [NUM_FIELDS-1:0] cmp_en_o
);
  logic [NUM_FIELDS-1:0] mask;
  rpt_mode_e             mode;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_mask
    assign mask[i] = bank_i[i][REG_W-1];
  end

  // prefix pattern, date mask is the most significant bit
  always_comb begin
    unique case (mask)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    unique case (mode)
      RPT_MONTH:  cmp_en_o = 4'b1111;
      RPT_DAY:    cmp_en_o = 4'b0111;
      RPT_HOUR:   cmp_en_o = 4'b0011;
      RPT_MINUTE: cmp_en_o = 4'b0001;
      default:    cmp_en_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  alarm_bank_t           bank_i,
  input  cal_bank_t             cal_i,
  input  logic [NUM_FIELDS-1:0] cmp_en_i,
  output logic                  hit_o
);
  logic [NUM_FIELDS-1:0] eq;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_eq
    assign eq[i] = (bank_i[i][VAL_W-1:0] == cal_i[i]);
  end

  assign hit_o = &(eq | ~cmp_en_i);
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_alarm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [VAL_W-1:0] cal_sec_i,
  input  logic [VAL_W-1:0] cal_min_i,
  input  logic [VAL_W-1:0] cal_hour_i,
  input  logic [VAL_W-1:0] cal_date_i,
  output logic             irq_o
);
  alarm_bank_t           alarm_q;
  cal_bank_t             cal;
  logic [NUM_FIELDS-1:0] cmp_en;
  logic                  hit;
  logic                  tick_q;
  logic                  irq_q;

  assign cal[IDX_SEC]  = cal_sec_i;
  assign cal[IDX_MIN]  = cal_min_i;
  assign cal[IDX_HOUR] = cal_hour_i;
  assign cal[IDX_DATE] = cal_date_i;

  rtc_alarm_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .bank_o   (alarm_q)
  );

  rtc_alarm_mode_dec u_dec (
    .bank_i  (alarm_q),
    .cmp_en_o(cmp_en)
  );

  rtc_alarm_cmp u_cmp (
    .bank_i  (alarm_q),
    .cal_i   (cal),
    .cmp_en_i(cmp_en),
    .hit_o   (hit)
  );

  // evaluate only on the tick's rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tick_q <= tick_i;
      irq_q  <= tick_i && !tick_q && hit;
    end
  end

  assign irq_o     = irq_q;
  assign rd_data_o = alarm_q[rd_sel_i];
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic             irq_o,
  input alarm_bank_t      alarm_q
);
  logic [3:0] m;
  logic       every_tick;

  assign m = {alarm_q[3][7], alarm_q[2][7], alarm_q[1][7], alarm_q[0][7]};
  assign every_tick = !(m == 4'b0000 || m == 4'b1000 || m == 4'b1100 || m == 4'b1110);

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R11

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i)); // R11

  AST_HELD_TICK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && $past(tick_i)) |=> !irq_o); // R12

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(alarm_q)); // R2

  AST_SEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((7'(alarm_q[0][6:4]) * 7'd10 + 7'(alarm_q[0][3:0])) <= 7'd59)); // R3

  AST_HOUR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((7'(alarm_q[2][5:4]) * 7'd10 + 7'(alarm_q[2][3:0])) <= 7'd23)); // R4

  AST_EVERY_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !$past(tick_i) && every_tick && !wr_en_i) |=> irq_o); // R10
endmodule

bind rtc_alarm rtc_alarm_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .wr_en_i(wr_en_i),
  .irq_o  (irq_o),
  .alarm_q(alarm_q)
);

// File: tb/tb_rtc_alarm.sv
module tb_rtc_alarm;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic [6:0] cal_sec_i = '0, cal_min_i = '0, cal_hour_i = '0, cal_date_i = '0;
  logic       irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk_i = ~clk_i;

  rtc_alarm dut (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .rd_sel_i, .rd_data_o, .cal_sec_i, .cal_min_i, .cal_hour_i,
    .cal_date_i, .irq_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int idx, input logic [7:0] d);
    int v;
    case (idx)
      0, 1: begin v = int'(d[6:4]) * 10 + int'(d[3:0]); return v <= 59; end
      2:    begin v = int'(d[5:4]) * 10 + int'(d[3:0]); return v <= 23; end
      default: begin v = int'(d[4]) * 10 + int'(d[3:0]); return v != 0; end
    endcase
  endfunction

  // which fields are compared for a mask pattern {date,hour,min,sec}
  function automatic logic [3:0] exp_cmp(input logic [3:0] m);
    if (m == 4'b0000) return 4'b1111;
    if (m == 4'b1000) return 4'b0111;
    if (m == 4'b1100) return 4'b0011;
    if (m == 4'b1110) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [7:0] rd(input logic [1:0] sel);
    rd_sel_i = sel;
    return dut.rd_data_o;
  endfunction

  task automatic fire(output logic got, output logic after);
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    got = irq_o;
    tick_i = 1'b0;
    @(negedge clk_i);
    after = irq_o;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] base [4];
    logic [6:0] alt  [4];
    logic got, after;
    base[0] = 7'h45; base[1] = 7'h30; base[2] = 7'h12; base[3] = 7'h15;
    alt[0]  = 7'h46; alt[1]  = 7'h31; alt[2]  = 7'h13; alt[3]  = 7'h16;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < 4; i++) begin
      rd_sel_i = 2'(i); #1;
      check(rd_data_o == 8'h00, "R1 reset reg", rd_data_o, 0);
    end
    check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);

    // R2 R3 R4 R5: full byte sweep on every field
    for (int f = 0; f < 4; f++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] old, expv;
        rd_sel_i = 2'(f); #1;
        old = rd_data_o;
        wr(2'(f), 8'(d));
        expv = exp_ok(f, 8'(d)) ? 8'(d) : old;
        rd_sel_i = 2'(f); #1;
        case (f)
          0, 1: check(rd_data_o == expv, "R3 R2 sec/min write", rd_data_o, expv);
          2:    check(rd_data_o == expv, "R4 R2 hour write", rd_data_o, expv);
          default: check(rd_data_o == expv, "R5 R2 date write", rd_data_o, expv);
        endcase
      end
    end

    // R6..R10, R13: every mask pattern, full match and single-field misses
    for (int mk = 0; mk < 16; mk++) begin
      logic [3:0] m, ce;
      m = 4'(mk);
      ce = exp_cmp(m);
      for (int f = 0; f < 4; f++) wr(2'(f), {m[f], base[f]});
      for (int miss = -1; miss < 4; miss++) begin
        bit expf;
        cal_sec_i  = (miss == 0) ? alt[0] : base[0];
        cal_min_i  = (miss == 1) ? alt[1] : base[1];
        cal_hour_i = (miss == 2) ? alt[2] : base[2];
        cal_date_i = (miss == 3) ? alt[3] : base[3];
        expf = (miss < 0) || !ce[miss];
        fire(got, after);
        if (mk == 0)       check(got == expf, "R6 month mode", got, expf);
        else if (mk == 8)  check(got == expf, "R7 day mode", got, expf);
        else if (mk == 12) check(got == expf, "R8 hour mode", got, expf);
        else if (mk == 14) check(got == expf, "R9 minute mode", got, expf);
        else               check(got == expf, "R10 every tick mode", got, expf);
        if (miss < 0) check(got == 1'b1, "R13 bit7 excluded", got, 1);
        check(after == 1'b0, "R11 pulse width", after, 0);
      end
    end

    // R11: matching calendar but no tick edge
    for (int f = 0; f < 4; f++) wr(2'(f), {1'b0, base[f]});
    cal_sec_i = base[0]; cal_min_i = base[1]; cal_hour_i = base[2]; cal_date_i = base[3];
    for (int c = 0; c < 6; c++) begin
      @(negedge clk_i);
      check(irq_o == 1'b0, "R11 no tick no irq", irq_o, 0);
    end

    // R12: held tick in every-second mode gives one pulse
    wr(2'd0, 8'h80);
    begin
      int pulses = 0;
      @(negedge clk_i);
      tick_i = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk_i);
        if (irq_o) pulses++;
      end
      tick_i = 1'b0;
      @(negedge clk_i);
      if (irq_o) pulses++;
      check(pulses == 1, "R12 held tick", pulses, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule